// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the register side of a classic byte-wide serial port. A host reaches eight byte registers through a 3-bit address. The serial line timing, the baud generator and the FIFOs are not part of this block. Bytes from the receive path arrive on a valid/ready stream and wait in a one-byte holding stage until the host reads the data register. A host write to the data register produces a one-cycle transmit strobe with the byte. Two interrupt sources, receive and transmit, each run a holdoff timer. A source's pending bit is set only `HOLDOFF` clock cycles after the event that triggers it. The level interrupt output is the OR of the two pending bits.

Each source has a small timer state machine with two states. `TMR_IDLE` goes to `TMR_ARMED` on *schedule*. `TMR_ARMED` goes to `TMR_ARMED` on *reschedule*, which reloads the count. `TMR_ARMED` goes to `TMR_IDLE` on *expire*, which sets the pending bit, or on *cancel*. `TMR_IDLE` stays in `TMR_IDLE` on *cancel*. The receive holding stage has two states. `HOLD_EMPTY` goes to `HOLD_FULL` on *load*. `HOLD_FULL` goes to `HOLD_EMPTY` on *pop without refill*. `HOLD_FULL` stays in `HOLD_FULL` on *pop with refill*. The transmit source also keeps an age counter. When the transmit enable is switched on, the counter decides whether the interrupt can be raised at once or must wait out the holdoff.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the enable register (offset 1), line control (offset 3) and modem control (offset 4) read 0, identification (offset 2) reads 0x01, `irq` is 0 and `rx_ready` is 1.
- R2: While line control bit 7 is 1, reads of offsets 0 and 1 return 0. Writes to them produce no transmit strobe and leave the enable register unchanged. Line control reads back all 8 bits written.
- R3: A read of offset 0 returns the held byte, or 0 if none is held, and frees the holding stage. The read clears the receive pending bit. If a new byte is loaded in the same cycle and enable bit 0 is 1, a receive interrupt is scheduled. Otherwise the receive timer is cancelled.
- R4: A write to offset 0 (bit 7 of line control clear) drives `tx_strobe` high for exactly the one cycle after the write, with `tx_data` equal to the byte. It clears the transmit pending bit, and it schedules a transmit interrupt when enable bit 1 is 1.
- R5: A read of offset 2 returns 0x04 if receive is pending, else 0x02 if transmit is pending, else 0x01. It clears the transmit pending bit only when receive is not pending, and it never clears the receive pending bit.
- R6: Offset 5 reads 0x60, with bit 0 set when a received byte is held.
- R7: Offsets 6 and 7 always read 0. Writes to offsets 7 and 2 have no effect on any readable register.
- R8: A write of 0x1A to offset 4 stores 0x9A. Any other value written there leaves the register unchanged.
- R9: A scheduled source sets its pending bit exactly `HOLDOFF` cycles after the scheduling edge. Scheduling again while the timer is armed restarts the full count.
- R10: Writing offset 1 with bit 1 set raises transmit pending in the same cycle if the last transmit interrupt was more than `HOLDOFF` cycles earlier, or if there has been none since reset. Otherwise it schedules a transmit interrupt. Writing bit 1 clear cancels the transmit timer and clears transmit pending.
- R11: Writing offset 1 with bit 0 set while a byte is held schedules a receive interrupt. Any other write to offset 1 cancels the receive timer and clears receive pending.
- R12: A byte loaded into the holding stage while enable bit 0 is 1 schedules a receive interrupt. While the stage is full, `rx_ready` is 0 unless offset 0 is being read.
- R13: `irq` is 1 exactly when at least one source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding stage accepts the byte this cycle |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_data | output | 8 | Transmitted byte, valid with the strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The checks assume that `bus_addr` and `bus_we` are known whenever `bus_sel` is high. They also assume that a write lasts one cycle, so the transmit strobe can be traced back to it. The receive stream is assumed to keep `rx_valid` and `rx_data` steady until `rx_ready` accepts the byte. The stimulus meets all of this: every bus access is a single-cycle pulse whose inputs change just after a clock edge. A received byte is only withdrawn after the edge that loaded it. The holdoff is shortened to 8 cycles so that immediate and delayed transmit paths, restarted timers and cancelled timers all fit in a short run.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int REG_W = 8;
    localparam int ADR_W = 3;

    localparam logic [ADR_W-1:0] OFF_DATA  = 3'd0;
    localparam logic [ADR_W-1:0] OFF_IEN   = 3'd1;
    localparam logic [ADR_W-1:0] OFF_IID   = 3'd2;
    localparam logic [ADR_W-1:0] OFF_LCTL  = 3'd3;
    localparam logic [ADR_W-1:0] OFF_MCTL  = 3'd4;
    localparam logic [ADR_W-1:0] OFF_LSTAT = 3'd5;

    localparam logic [REG_W-1:0] IID_RX   = 8'h04;
    localparam logic [REG_W-1:0] IID_TX   = 8'h02;
    localparam logic [REG_W-1:0] IID_NONE = 8'h01;

    localparam logic [REG_W-1:0] MCTL_KEY   = 8'h1A;
    localparam logic [REG_W-1:0] MCTL_STORE = 8'h9A;
    localparam logic [REG_W-1:0] LSTAT_IDLE = 8'h60;

    localparam int IEN_RX_BIT = 0;
    localparam int IEN_TX_BIT = 1;
    localparam int LCTL_DIV_BIT = 7;

    localparam int NSRC   = 2;
    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;

    typedef enum logic [0:0] {TMR_IDLE, TMR_ARMED} tmr_state_e;
    typedef enum logic [0:0] {HOLD_EMPTY, HOLD_FULL} hold_state_e;

    typedef struct packed {
        logic sched;
        logic fire_now;
        logic cancel;
        logic clr_pend;
    } src_ctl_t;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_fe_pkg::*;
#(
    parameter int HOLDOFF   = 23,
    parameter bit TRACK_AGE = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_ctl_t ctl,
    output logic     pending,
    output logic     recent
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLDOFF);
    localparam logic [CW-1:0] LAST = CW'(1);

    tmr_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           expire;
    logic           fire;
    logic           pend_q, pend_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: schedule / reschedule / expire / cancel
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                cnt_d = cnt_q;
            end
            TMR_ARMED: begin
                if (cnt_q == LAST) begin
                    expire  = 1'b1;
                    state_d = TMR_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
        if (ctl.cancel) begin
            state_d = TMR_IDLE;
            expire  = 1'b0;
        end else if (ctl.sched) begin
            state_d = TMR_ARMED;
            cnt_d   = LOAD;
            expire  = 1'b0;
        end
    end

    assign fire   = expire | (ctl.fire_now & ~ctl.cancel);
    assign pend_d = ctl.cancel ? 1'b0 : ((pend_q & ~ctl.clr_pend) | fire);

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
    assign pending = pend_q;

    generate
        if (TRACK_AGE) begin : g_age
            logic [CW-1:0] age_q;
            always_ff @(posedge clk) begin
                if (!rst_n)            age_q <= '0;
                else if (fire)         age_q <= LOAD;
                else if (age_q != '0)  age_q <= age_q - 1'b1;
            end
            assign recent = (age_q != '0);
        end else begin : g_no_age
            assign recent = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] in_data,
    output logic             in_ready,
    input  logic             pop,
    output logic             avail,
    output logic [REG_W-1:0] held,
    output logic             load
);
    hold_state_e      state_q, state_d;
    logic [REG_W-1:0] byte_q;

    assign in_ready = (state_q == HOLD_EMPTY) | pop;
    assign load     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    // load / pop with refill / pop without refill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (load) state_d = HOLD_FULL;
            HOLD_FULL:  if (pop && !load) state_d = HOLD_EMPTY;
            default:    state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (load) byte_q <= in_data;
    end

    assign avail = (state_q == HOLD_FULL);
    assign held  = byte_q;
endmodule

// File: rtl/uart_csr.sv
module uart_csr
    import uart_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             rx_avail,
    input  logic [REG_W-1:0] rx_byte,
    input  logic             rx_load,
    output logic             rx_pop,
    input  logic             rx_pend,
    input  logic             tx_pend,
    input  logic             tx_recent,
    output src_ctl_t         rx_ctl,
    output src_ctl_t         tx_ctl,
    output logic             tx_strobe,
    output logic [REG_W-1:0] tx_data,
    output logic [REG_W-1:0] lctl,
    output logic [REG_W-1:0] mctl
);
    logic [REG_W-1:0] ien_q, lctl_q, mctl_q, txd_q;
    logic             stb_q;
    logic             rd, wr, div_mode;
    logic             data_rd, data_wr, ien_wr, iid_rd;
    logic [REG_W-1:0] iid_code;

    assign rd       = bus_sel & ~bus_we;
    assign wr       = bus_sel &  bus_we;
    assign div_mode = lctl_q[LCTL_DIV_BIT];

    assign data_rd = rd & (bus_addr == OFF_DATA) & ~div_mode;
    assign data_wr = wr & (bus_addr == OFF_DATA) & ~div_mode;
    assign ien_wr  = wr & (bus_addr == OFF_IEN)  & ~div_mode;
    assign iid_rd  = rd & (bus_addr == OFF_IID);

    assign iid_code = rx_pend ? IID_RX : (tx_pend ? IID_TX : IID_NONE);

    always_comb begin
        unique case (bus_addr)
            OFF_DATA:  bus_rdata = (div_mode || !rx_avail) ? '0 : rx_byte;
            OFF_IEN:   bus_rdata = div_mode ? '0 : ien_q;
            OFF_IID:   bus_rdata = iid_code;
            OFF_LCTL:  bus_rdata = lctl_q;
            OFF_MCTL:  bus_rdata = mctl_q;
            OFF_LSTAT: bus_rdata = LSTAT_IDLE | {{(REG_W-1){1'b0}}, rx_avail};
            default:   bus_rdata = '0;
        endcase
    end

    assign rx_pop = data_rd;

    always_comb begin
        tx_ctl.fire_now = ien_wr & bus_wdata[IEN_TX_BIT] & ~tx_recent;
        tx_ctl.sched    = (ien_wr & bus_wdata[IEN_TX_BIT] & tx_recent)
                        | (data_wr & ien_q[IEN_TX_BIT]);
        tx_ctl.cancel   = ien_wr & ~bus_wdata[IEN_TX_BIT];
        tx_ctl.clr_pend = data_wr | (iid_rd & ~rx_pend);

        rx_ctl.fire_now = 1'b0;
        rx_ctl.sched    = (ien_wr & bus_wdata[IEN_RX_BIT] & rx_avail)
                        | (rx_load & ien_q[IEN_RX_BIT]);
        rx_ctl.cancel   = (ien_wr & ~(bus_wdata[IEN_RX_BIT] & rx_avail))
                        | (data_rd & ~rx_load);
        rx_ctl.clr_pend = data_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            stb_q  <= 1'b0;
            txd_q  <= '0;
        end else begin
            stb_q <= data_wr;
            if (data_wr) txd_q <= bus_wdata;
            if (ien_wr)  ien_q <= bus_wdata;
            if (wr && bus_addr == OFF_LCTL) lctl_q <= bus_wdata;
            if (wr && bus_addr == OFF_MCTL && bus_wdata == MCTL_KEY) mctl_q <= MCTL_STORE;
        end
    end

    assign tx_strobe = stb_q;
    assign tx_data   = txd_q;
    assign lctl      = lctl_q;
    assign mctl      = mctl_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_fe_pkg::*;
#(
    parameter int HOLDOFF = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_strobe,
    output logic [7:0] tx_data,
    output logic       irq
);
    logic             avail, load, pop;
    logic [REG_W-1:0] held;
    logic [REG_W-1:0] lctl_w, mctl_w;
    src_ctl_t         ctl   [NSRC];
    logic             pend  [NSRC];
    logic             recent[NSRC];

    uart_rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_ready (rx_ready),
        .pop      (pop),
        .avail    (avail),
        .held     (held),
        .load     (load)
    );

    uart_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_avail  (avail),
        .rx_byte   (held),
        .rx_load   (load),
        .rx_pop    (pop),
        .rx_pend   (pend[SRC_RX]),
        .tx_pend   (pend[SRC_TX]),
        .tx_recent (recent[SRC_TX]),
        .rx_ctl    (ctl[SRC_RX]),
        .tx_ctl    (ctl[SRC_TX]),
        .tx_strobe (tx_strobe),
        .tx_data   (tx_data),
        .lctl      (lctl_w),
        .mctl      (mctl_w)
    );

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            uart_irq_src #(
                .HOLDOFF   (HOLDOFF),
                .TRACK_AGE (s == SRC_TX)
            ) u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .ctl     (ctl[s]),
                .pending (pend[s]),
                .recent  (recent[s])
            );
        end
    endgenerate

    assign irq = pend[SRC_RX] | pend[SRC_TX];
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       tx_strobe,
    input logic       irq,
    input logic [7:0] lctl,
    input logic [7:0] mctl
);
    logic rd;
    assign rd = bus_sel && !bus_we;

    // R2: divisor-latch mode hides data and enable registers
    a_r2_div_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr <= 3'd1 && lctl[7]) |-> (bus_rdata == 8'h00));

    // R4: a strobe always follows a data-register write
    a_r4_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_sel && bus_we && bus_addr == 3'd0));

    // R5: identification code is a single known bit
    a_r5_iid_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 3'd2) |-> ($countones(bus_rdata) == 1 && bus_rdata[7:3] == 5'd0));

    // R6: line status fixed bits
    a_r6_lstat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[4:1] == 4'd0 && !bus_rdata[7]));

    // R7: modem status and scratch read zero
    a_r7_zero_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr >= 3'd6) |-> (bus_rdata == 8'h00));

    // R8: only the key value changes modem control
    a_r8_mctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd4 && bus_wdata != 8'h1A) |=> $stable(mctl));

    // R10, R11: disabling both sources drops the request
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd1 && !lctl[7] && bus_wdata[1:0] == 2'b00) |=> !irq);

    // R13: request line agrees with the identification code
    a_r13_irq_matches_iid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 3'd2) |-> (irq == (bus_rdata != 8'h01)));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_strobe (tx_strobe),
    .irq       (irq),
    .lctl      (lctl_w),
    .mctl      (mctl_w)
);

// File: tb/sim_uart_regfile.sv
`timescale 1ns/1ps
module sim_uart_regfile;
    localparam int HO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_strobe, irq;
    logic [7:0] tx_data;

    int total = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    uart_regfile #(.HOLDOFF(HO)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underrun", bus_rdata, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        tick();
        rx_valid = 1'b0;
    endtask

    // after a scheduling edge: irq low for HO-1 cycles, high at HO
    task automatic expect_delayed(input string tag);
        repeat (HO - 1) tick();
        chk(irq == 1'b0, tag, irq, 0);
        tick();
        chk(irq == 1'b1, tag, irq, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
        rd(3'd1, 8'h00, "R1 enable");
        rd(3'd3, 8'h00, "R1 line control");
        rd(3'd4, 8'h00, "R1 modem control");
        rd(3'd2, 8'h01, "R1 identification");
        rd(3'd5, 8'h60, "R6 line status empty");

        // R7 fixed-zero registers, ignored writes
        wr(3'd7, 8'hFF);
        rd(3'd7, 8'h00, "R7 scratch");
        rd(3'd6, 8'h00, "R7 modem status");
        wr(3'd2, 8'hC7);
        rd(3'd2, 8'h01, "R7 fifo control write ignored");
        rd(3'd1, 8'h00, "R7 enable untouched");

        // R8 modem control key
        wr(3'd4, 8'h55);
        rd(3'd4, 8'h00, "R8 non-key write");
        wr(3'd4, 8'h1A);
        rd(3'd4, 8'h9A, "R8 key write");
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h9A, "R8 hold after other write");

        // R2 divisor latch mode
        wr(3'd3, 8'h83);
        rd(3'd3, 8'h83, "R2 line control readback");
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h41);
        chk(tx_strobe == 1'b0, "R2 no strobe", tx_strobe, 0);
        rd(3'd0, 8'h00, "R2 data reads zero");
        rd(3'd1, 8'h00, "R2 enable reads zero");
        wr(3'd3, 8'h03);
        rd(3'd1, 8'h00, "R2 enable write ignored");
        chk(irq == 1'b0, "R2 irq", irq, 0);

        // R4 transmit strobe
        wr(3'd0, 8'h5A);
        chk(tx_strobe == 1'b1, "R4 strobe", tx_strobe, 1);
        chk(tx_data == 8'h5A, "R4 data", tx_data, 8'h5A);
        tick();
        chk(tx_strobe == 1'b0, "R4 strobe one cycle", tx_strobe, 0);

        // R10 immediate raise with no previous transmit interrupt
        wr(3'd1, 8'h02);
        chk(irq == 1'b1, "R10 immediate", irq, 1);
        rd(3'd2, 8'h02, "R5 transmit code");
        chk(irq == 1'b0, "R5 read clears transmit", irq, 0);
        rd(3'd2, 8'h01, "R5 none after clear");
        // R10 recent interrupt: delayed
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        chk(irq == 1'b0, "R10 recent not immediate", irq, 0);
        expect_delayed("R10 delayed raise");
        rd(3'd2, 8'h02, "R5 transmit code again");

        // R10 cancel of a scheduled transmit interrupt
        wr(3'd0, 8'h11);
        repeat (3) tick();
        wr(3'd1, 8'h00);
        repeat (HO + 2) tick();
        chk(irq == 1'b0, "R10 cancel", irq, 0);

        // R9 restart of an armed timer
        wr(3'd1, 8'h02);
        chk(irq == 1'b1, "R10 old interrupt immediate", irq, 1);
        rd(3'd2, 8'h02, "R5 clear before restart");
        wr(3'd0, 8'h22);
        chk(irq == 1'b0, "R4 write clears transmit", irq, 0);
        repeat (3) tick();
        wr(3'd0, 8'h33);
        expect_delayed("R9 restarted holdoff");
        rd(3'd2, 8'h02, "R9 transmit code");
        wr(3'd1, 8'h00);

        // R11 receive interrupt from enable write, R5 priority, R3 read
        push_rx(8'hA5);
        rd(3'd5, 8'h61, "R6 data ready");
        chk(irq == 1'b0, "R11 no irq while disabled", irq, 0);
        wr(3'd1, 8'h01);
        expect_delayed("R11 receive holdoff");
        rd(3'd2, 8'h04, "R5 receive code");
        rd(3'd2, 8'h04, "R5 receive not cleared by read");
        wr(3'd1, 8'h03);
        rd(3'd2, 8'h04, "R5 receive before transmit");
        rd(3'd0, 8'hA5, "R3 byte read");
        chk(irq == 1'b1, "R13 transmit still pending", irq, 1);
        rd(3'd2, 8'h02, "R5 transmit after receive");
        chk(irq == 1'b0, "R13 none pending", irq, 0);
        rd(3'd0, 8'h00, "R3 empty read");
        rd(3'd5, 8'h60, "R6 data ready clear");

        // R12 arrival scheduling and refill on read
        wr(3'd1, 8'h01);
        push_rx(8'h3C);
        expect_delayed("R12 arrival holdoff");
        rx_valid = 1'b1; rx_data = 8'h4D;
        tick();
        chk(rx_ready == 1'b0, "R12 stage full", rx_ready, 0);
        rd(3'd0, 8'h3C, "R3 first byte");
        rx_valid = 1'b0;
        chk(irq == 1'b0, "R3 read clears receive", irq, 0);
        expect_delayed("R12 refill reschedules");
        rd(3'd0, 8'h4D, "R3 second byte");
        chk(irq == 1'b0, "R13 irq low after last byte", irq, 0);
        repeat (HO + 2) tick();
        chk(irq == 1'b0, "R3 timer cancelled when empty", irq, 0);

        tick();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule